// File: doc/BRIEF.md
# Masked-Write Clock Control Register Bank

This block is the software-visible control store of a clock-and-reset unit. It holds four PLL control words, a set of clock-select/divider words, a set of clock-gate words and a set of soft-reset words. Software reaches them through a 32-bit register port built as two valid/ready channels: a request channel (read or write, address, write data) and a response channel that returns one beat per accepted request. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops only while a response beat is waiting and `rsp_ready` is low. A held response keeps its data unchanged until it is taken.

Almost every register uses a split-half write: the upper 16 bits of the write data form a per-bit enable for the lower 16 bits. Software can therefore change one field without reading the word first. The fractional-divider PLL word is the exception. It is written as a plain word, and its top bit reports the PLL lock state after a synchronizer. The stored bits drive decoded fields to the clock tree: PLL dividers, the work mode, the integer-mode select, divider ratios, per-clock enables and soft-reset lines.

The address map is word-aligned, and address bits 1:0 are ignored. PLL words sit at 0x000 + 4n (n = 0..3). Select words sit at 0x080 + 4n (n < NUM_SEL). Gate words sit at 0x100 + 4n (n < NUM_GATE, at most 4). Soft-reset words sit at 0x110 + 4n (n < NUM_RST).

Top module: `ckreg_bank`

## Requirements
- R1: Each accepted request yields exactly one response beat. That beat becomes valid on the edge that accepts the request. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` holds steady.
- R2: In every masked word (PLL words 0, 1 and 3, and all select, gate and soft-reset words), stored bit i (i < 16) takes write-data bit i only when write-data bit i+16 is 1. Otherwise it keeps its value.
- R3: A read of a masked word returns the 16 stored bits in bits 15:0 and zero in bits 31:16.
- R4: A write to PLL word 2 (offset 0x008) stores write-data bits 23:0 with no mask. A read of that word returns the stored value in bits 23:0, zero in bits 30:24, and in bit 31 the lock input delayed by LOCK_STAGES register stages. Writes never affect bit 31.
- R5: The PLL outputs are decoded as follows. From word 0: feedback divider = bits 11:0. From word 1: second post-divider = bits 14:12, first post-divider = bits 10:8, reference divider = bits 5:0. From word 3: work mode = bits 9:8 (0 slow, 1 normal, 2 deep slow) and integer-mode select = bit 3.
- R6: Select word s drives two 7-bit divider fields, bits 6:0 on `div_lo_o[7s+6:7s]` and bits 14:8 on `div_hi_o[7s+6:7s]`. Select word 0 bits 4:0 also drive the 5-bit bus-clock divider `div_bus_o`.
- R7: Gate word g bit i set to 1 stops clock 16g+i. `clk_en_o[16g+i]` is the inverse of that stored bit.
- R8: Soft-reset word r bit i drives `soft_rst_o[16r+i]` directly, where 1 means reset is asserted.
- R9: Reads of unmapped offsets return zero. Writes to unmapped offsets change no stored bit.
- R10: After reset, all stored bits are zero. This gives all divider fields 0, work mode slow, all `clk_en_o` high, all `soft_rst_o` low and `rsp_valid` low.
- R11: The response beat of a write carries all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data (upper half is the bit mask for masked words) |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data, zero for writes |
| pll_lock_i | input | 1 | Asynchronous PLL lock indication |
| pll_fbdiv_o | output | 12 | Feedback divider |
| pll_postdiv1_o | output | 3 | First post-divider |
| pll_postdiv2_o | output | 3 | Second post-divider |
| pll_refdiv_o | output | 6 | Reference divider |
| pll_frac_o | output | 24 | Fractional divider |
| pll_mode_o | output | 2 | Work mode |
| pll_int_mode_o | output | 1 | Integer-mode select |
| div_bus_o | output | 5 | Bus-clock source divider |
| div_lo_o | output | NUM_SEL*7 | Low divider field of each select word |
| div_hi_o | output | NUM_SEL*7 | High divider field of each select word |
| clk_en_o | output | NUM_GATE*16 | Per-clock enables |
| soft_rst_o | output | NUM_RST*16 | Soft-reset lines |

## Verification
The bench builds the bank with NUM_SEL=5, NUM_GATE=4, NUM_RST=3 and LOCK_STAGES=2. Four gate words fill the gate region up to 0x10C, directly below the first soft-reset word at 0x110. That layout lets the bench test the decode edge between the two regions, the first unmapped word above each region (0x094, 0x11C, 0x010), and the use of every bit of the widest gate vector. A pseudo-random stall pattern on `rsp_ready` applies back-pressure across a sweep of all sixteen mapped words.

// File: rtl/ckreg_pkg.sv
package ckreg_pkg;
  localparam int ADDR_W     = 12;
  localparam int PLL_WORDS  = 4;
  localparam int FRAC_IDX   = 2;
  localparam int SEL_BASE   = 'h080;
  localparam int GATE_BASE  = 'h100;
  localparam int RST_BASE   = 'h110;
  localparam int GATE_MAX   = (RST_BASE - GATE_BASE) / 4;

  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_PLL  = 3'd1,
    RGN_SEL  = 3'd2,
    RGN_GATE = 3'd3,
    RGN_RST  = 3'd4
  } region_e;

  typedef enum logic [1:0] {
    MODE_SLOW   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_DEEP   = 2'd2
  } pll_mode_e;

  function automatic logic [15:0] masked_merge(input logic [15:0] old_v,
                                               input logic [31:0] wd);
    return (old_v & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
  endfunction
endpackage

// File: rtl/ckreg_decode.sv
module ckreg_decode
  import ckreg_pkg::*;
#(
  parameter int NUM_SEL  = 4,
  parameter int NUM_GATE = 2,
  parameter int NUM_RST  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [4:0]        idx_o
);
  localparam logic [9:0] SEL_W0  = 10'(SEL_BASE / 4);
  localparam logic [9:0] GATE_W0 = 10'(GATE_BASE / 4);
  localparam logic [9:0] RST_W0  = 10'(RST_BASE / 4);

  logic [9:0] word;
  logic       unused_lsb;
  assign word       = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];

  always_comb begin
    region_o = RGN_NONE;
    idx_o    = '0;
    if (word < 10'(PLL_WORDS)) begin
      region_o = RGN_PLL;
      idx_o    = word[4:0];
    end else if (word >= SEL_W0 && word < SEL_W0 + 10'(NUM_SEL)) begin
      region_o = RGN_SEL;
      idx_o    = word[4:0] - SEL_W0[4:0];
    end else if (word >= GATE_W0 && word < GATE_W0 + 10'(NUM_GATE)) begin
      region_o = RGN_GATE;
      idx_o    = word[4:0] - GATE_W0[4:0];
    end else if (word >= RST_W0 && word < RST_W0 + 10'(NUM_RST)) begin
      region_o = RGN_RST;
      idx_o    = word[4:0] - RST_W0[4:0];
    end
  end
endmodule

// File: rtl/ckreg_mword.sv
module ckreg_mword
  import ckreg_pkg::*;
#(
  parameter logic [15:0] RST_VAL = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [15:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= RST_VAL;
    else if (we_i) q_o <= masked_merge(q_o, wdata_i);
  end
endmodule

// File: rtl/ckreg_sync.sv
module ckreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d_i};
  end
  assign q_o = sh[STAGES-1];
endmodule

// File: rtl/ckreg_bank.sv
module ckreg_bank
  import ckreg_pkg::*;
#(
  parameter int NUM_SEL     = 4,
  parameter int NUM_GATE    = 2,
  parameter int NUM_RST     = 2,
  parameter int LOCK_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [31:0]             rsp_rdata,
  input  logic                    pll_lock_i,
  output logic [11:0]             pll_fbdiv_o,
  output logic [2:0]              pll_postdiv1_o,
  output logic [2:0]              pll_postdiv2_o,
  output logic [5:0]              pll_refdiv_o,
  output logic [23:0]             pll_frac_o,
  output logic [1:0]              pll_mode_o,
  output logic                    pll_int_mode_o,
  output logic [4:0]              div_bus_o,
  output logic [NUM_SEL*7-1:0]    div_lo_o,
  output logic [NUM_SEL*7-1:0]    div_hi_o,
  output logic [NUM_GATE*16-1:0]  clk_en_o,
  output logic [NUM_RST*16-1:0]   soft_rst_o
);
  if (NUM_SEL < 1 || NUM_SEL > 32)        begin : g_bad_sel  $error("NUM_SEL out of range");  end
  if (NUM_GATE < 1 || NUM_GATE > GATE_MAX) begin : g_bad_gate $error("NUM_GATE out of range"); end
  if (NUM_RST < 1 || NUM_RST > 16)        begin : g_bad_rst  $error("NUM_RST out of range");  end
  if (LOCK_STAGES < 2)                    begin : g_bad_sync $error("LOCK_STAGES below 2");   end

  logic    accept, wr_acc;
  region_e region;
  logic [4:0] idx;
  logic    lock_s;
  logic [31:0] rd_data;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;

  ckreg_decode #(.NUM_SEL(NUM_SEL), .NUM_GATE(NUM_GATE), .NUM_RST(NUM_RST)) u_dec (
    .addr_i(req_addr), .region_o(region), .idx_o(idx)
  );

  ckreg_sync #(.STAGES(LOCK_STAGES)) u_lock_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pll_lock_i), .q_o(lock_s)
  );

  // PLL words: full-width read images
  logic [31:0] pll_rd [PLL_WORDS];
  for (genvar w = 0; w < PLL_WORDS; w++) begin : g_pll
    logic we_w;
    assign we_w = wr_acc && (region == RGN_PLL) && (idx == 5'(w));
    if (w == FRAC_IDX) begin : g_frac
      logic [23:0] frac_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    frac_q <= '0;
        else if (we_w) frac_q <= req_wdata[23:0];
      end
      assign pll_rd[w] = {lock_s, 7'h00, frac_q};
    end else begin : g_mask
      logic [15:0] q;
      ckreg_mword u_w (.clk(clk), .rst_n(rst_n), .we_i(we_w), .wdata_i(req_wdata), .q_o(q));
      assign pll_rd[w] = {16'h0000, q};
    end
  end

  // Select/divider words
  logic [15:0] sel_q [NUM_SEL];
  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    logic we_s;
    assign we_s = wr_acc && (region == RGN_SEL) && (idx == 5'(s));
    ckreg_mword u_w (.clk(clk), .rst_n(rst_n), .we_i(we_s), .wdata_i(req_wdata), .q_o(sel_q[s]));
    assign div_lo_o[s*7 +: 7] = sel_q[s][6:0];
    assign div_hi_o[s*7 +: 7] = sel_q[s][14:8];
  end

  // Gate words: a stored 1 stops the clock
  logic [15:0] gate_q [NUM_GATE];
  for (genvar g = 0; g < NUM_GATE; g++) begin : g_gate
    logic we_g;
    assign we_g = wr_acc && (region == RGN_GATE) && (idx == 5'(g));
    ckreg_mword u_w (.clk(clk), .rst_n(rst_n), .we_i(we_g), .wdata_i(req_wdata), .q_o(gate_q[g]));
    assign clk_en_o[g*16 +: 16] = ~gate_q[g];
  end

  // Soft-reset words
  logic [15:0] rst_q [NUM_RST];
  for (genvar r = 0; r < NUM_RST; r++) begin : g_rst
    logic we_r;
    assign we_r = wr_acc && (region == RGN_RST) && (idx == 5'(r));
    ckreg_mword u_w (.clk(clk), .rst_n(rst_n), .we_i(we_r), .wdata_i(req_wdata), .q_o(rst_q[r]));
    assign soft_rst_o[r*16 +: 16] = rst_q[r];
  end

  // Read mux
  always_comb begin
    rd_data = '0;
    unique case (region)
      RGN_PLL:  for (int w = 0; w < PLL_WORDS; w++) if (idx == 5'(w)) rd_data = pll_rd[w];
      RGN_SEL:  for (int s = 0; s < NUM_SEL;  s++) if (idx == 5'(s)) rd_data = {16'h0000, sel_q[s]};
      RGN_GATE: for (int g = 0; g < NUM_GATE; g++) if (idx == 5'(g)) rd_data = {16'h0000, gate_q[g]};
      RGN_RST:  for (int r = 0; r < NUM_RST;  r++) if (idx == 5'(r)) rd_data = {16'h0000, rst_q[r]};
      default:  rd_data = '0;
    endcase
  end

  // Response channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? 32'h0 : rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // Decoded PLL fields
  assign pll_fbdiv_o    = pll_rd[0][11:0];
  assign pll_postdiv2_o = pll_rd[1][14:12];
  assign pll_postdiv1_o = pll_rd[1][10:8];
  assign pll_refdiv_o   = pll_rd[1][5:0];
  assign pll_frac_o     = pll_rd[FRAC_IDX][23:0];
  assign pll_mode_o     = pll_rd[3][9:8];
  assign pll_int_mode_o = pll_rd[3][3];
  assign div_bus_o      = sel_q[0][4:0];
endmodule

// File: rtl/ckreg_bank_chk.sv
module ckreg_bank_chk
  import ckreg_pkg::*;
#(
  parameter int NUM_SEL  = 4,
  parameter int NUM_GATE = 2,
  parameter int NUM_RST  = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic [ADDR_W-1:0]      req_addr,
  input logic [31:0]            req_wdata,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [31:0]            rsp_rdata,
  input logic [11:0]            pll_fbdiv_o,
  input logic [23:0]            pll_frac_o,
  input logic [NUM_SEL*7-1:0]   div_lo_o,
  input logic [NUM_SEL*7-1:0]   div_hi_o,
  input logic [NUM_GATE*16-1:0] clk_en_o,
  input logic [NUM_RST*16-1:0]  soft_rst_o
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R1
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R11
  wr_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write |=> rsp_rdata == 32'h0);

  // R3
  sel_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && req_addr[11:7] == 5'b00001 |=> rsp_rdata[31:16] == 16'h0);

  // R2
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_addr[11:2] == 10'(SEL_BASE / 4) && req_wdata[31:16] == 16'h0
    |=> $stable(div_lo_o) && $stable(div_hi_o));

  // R4
  frac_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_addr[11:2] == 10'(FRAC_IDX) |=> pll_frac_o == $past(req_wdata[23:0]));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_addr[11:9] != 3'b000
    |=> $stable(div_lo_o) && $stable(div_hi_o) && $stable(clk_en_o) && $stable(soft_rst_o)
        && $stable(pll_fbdiv_o) && $stable(pll_frac_o));
endmodule

bind ckreg_bank ckreg_bank_chk #(.NUM_SEL(NUM_SEL), .NUM_GATE(NUM_GATE), .NUM_RST(NUM_RST)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .pll_fbdiv_o(pll_fbdiv_o), .pll_frac_o(pll_frac_o), .div_lo_o(div_lo_o),
  .div_hi_o(div_hi_o), .clk_en_o(clk_en_o), .soft_rst_o(soft_rst_o)
);

// File: tb/ckreg_bank_tb.sv
module ckreg_bank_tb_top;
  import ckreg_pkg::*;
  localparam int NS = 5, NG = 4, NR = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1, pll_lock_i = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [11:0] pll_fbdiv_o;
  logic [2:0]  pll_postdiv1_o, pll_postdiv2_o;
  logic [5:0]  pll_refdiv_o;
  logic [23:0] pll_frac_o;
  logic [1:0]  pll_mode_o;
  logic        pll_int_mode_o;
  logic [4:0]  div_bus_o;
  logic [NS*7-1:0]  div_lo_o, div_hi_o;
  logic [NG*16-1:0] clk_en_o;
  logic [NR*16-1:0] soft_rst_o;

  ckreg_bank #(.NUM_SEL(NS), .NUM_GATE(NG), .NUM_RST(NR), .LOCK_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pll_lock_i(pll_lock_i), .pll_fbdiv_o(pll_fbdiv_o), .pll_postdiv1_o(pll_postdiv1_o),
    .pll_postdiv2_o(pll_postdiv2_o), .pll_refdiv_o(pll_refdiv_o), .pll_frac_o(pll_frac_o),
    .pll_mode_o(pll_mode_o), .pll_int_mode_o(pll_int_mode_o), .div_bus_o(div_bus_o),
    .div_lo_o(div_lo_o), .div_hi_o(div_hi_o), .clk_en_o(clk_en_o), .soft_rst_o(soft_rst_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference model
  logic [15:0] m_pll [4];
  logic [23:0] m_frac;
  logic [15:0] m_sel [NS];
  logic [15:0] m_gate [NG];
  logic [15:0] m_rst [NR];
  logic [11:0] map_addr [16];

  bit bp_en = 1'b0;
  logic [7:0] bp_lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    bp_lfsr   <= {bp_lfsr[6:0], bp_lfsr[7] ^ bp_lfsr[5] ^ bp_lfsr[4] ^ bp_lfsr[3]};
    rsp_ready <= bp_en ? bp_lfsr[0] : 1'b1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor (R1: one beat per accepted request, in order)
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 extra response: actual %0h expected none", rsp_rdata);
      end else begin
        string t;
        logic [31:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        check(t, {32'h0, rsp_rdata}, {32'h0, e});
      end
    end
  end

  function automatic logic [15:0] mmerge(input logic [15:0] o, input logic [31:0] d);
    return (o & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int w;
    w = int'(a[11:2]);
    if (w < 4) return (w == 2) ? {pll_lock_i, 7'h0, m_frac} : {16'h0, m_pll[w]};
    if (w >= 32 && w < 32 + NS) return {16'h0, m_sel[w-32]};
    if (w >= 64 && w < 64 + NG) return {16'h0, m_gate[w-64]};
    if (w >= 68 && w < 68 + NR) return {16'h0, m_rst[w-68]};
    return 32'h0;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    int w;
    w = int'(a[11:2]);
    if (w == 2) m_frac = d[23:0];
    else if (w < 4) m_pll[w] = mmerge(m_pll[w], d);
    else if (w >= 32 && w < 32 + NS) m_sel[w-32] = mmerge(m_sel[w-32], d);
    else if (w >= 64 && w < 64 + NG) m_gate[w-64] = mmerge(m_gate[w-64], d);
    else if (w >= 68 && w < 68 + NR) m_rst[w-68] = mmerge(m_rst[w-68], d);
  endtask

  task automatic do_req(input bit wr, input logic [11:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(wr ? 32'h0 : model_read(a));
    tag_q.push_back(tag);
    if (wr) model_write(a, d);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_fields(input string tag);
    logic [NS*7-1:0] lo, hi;
    logic [NG*16-1:0] en;
    logic [NR*16-1:0] sr;
    for (int s = 0; s < NS; s++) begin lo[s*7 +: 7] = m_sel[s][6:0]; hi[s*7 +: 7] = m_sel[s][14:8]; end
    for (int g = 0; g < NG; g++) en[g*16 +: 16] = ~m_gate[g];
    for (int r = 0; r < NR; r++) sr[r*16 +: 16] = m_rst[r];
    check({"R5 fbdiv ", tag}, 64'(pll_fbdiv_o), 64'(m_pll[0][11:0]));
    check({"R5 post/ref ", tag}, 64'({pll_postdiv2_o, pll_postdiv1_o, pll_refdiv_o}),
          64'({m_pll[1][14:12], m_pll[1][10:8], m_pll[1][5:0]}));
    check({"R5 mode/int ", tag}, 64'({pll_mode_o, pll_int_mode_o}), 64'({m_pll[3][9:8], m_pll[3][3]}));
    check({"R4 frac ", tag}, 64'(pll_frac_o), 64'(m_frac));
    check({"R6 div_bus ", tag}, 64'(div_bus_o), 64'(m_sel[0][4:0]));
    check({"R6 div_lo ", tag}, 64'(div_lo_o), 64'(lo));
    check({"R6 div_hi ", tag}, 64'(div_hi_o), 64'(hi));
    check({"R7 clk_en ", tag}, 64'(clk_en_o), 64'(en));
    check({"R8 soft_rst ", tag}, 64'(soft_rst_o), 64'(sr));
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hang expected completion");
      finish_sim();
    end
  end

  initial begin
    logic [31:0] rnd;
    for (int i = 0; i < 4; i++) m_pll[i] = '0;
    for (int i = 0; i < NS; i++) m_sel[i] = '0;
    for (int i = 0; i < NG; i++) m_gate[i] = '0;
    for (int i = 0; i < NR; i++) m_rst[i] = '0;
    m_frac = '0;
    for (int i = 0; i < 4; i++)  map_addr[i]          = 12'(4 * i);
    for (int i = 0; i < NS; i++) map_addr[4 + i]      = 12'('h080 + 4 * i);
    for (int i = 0; i < NG; i++) map_addr[4 + NS + i] = 12'('h100 + 4 * i);
    for (int i = 0; i < NR; i++) map_addr[4 + NS + NG + i] = 12'('h110 + 4 * i);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 rsp_valid after reset", 64'(rsp_valid), 64'(0));
    check("R10 req_ready after reset", 64'(req_ready), 64'(1));
    check("R10 clk_en all on", 64'(clk_en_o), 64'({NG*16{1'b1}}));
    check("R10 mode slow", 64'(pll_mode_o), 64'(MODE_SLOW));
    chk_fields("R10 reset");
    for (int i = 0; i < 16; i++) do_req(1'b0, map_addr[i], 32'h0, "R10 R3 reset readback");
    drain();

    // R2 masked writes on select word 0
    do_req(1'b1, 12'h080, 32'h001F_0013, "R11 write rsp");
    do_req(1'b1, 12'h080, 32'h0000_FFFF, "R11 write rsp");
    do_req(1'b1, 12'h080, 32'h7F00_2A00, "R11 write rsp");
    do_req(1'b0, 12'h083, 32'h0, "R3 R2 sel0 readback, addr lsbs ignored");
    drain();
    chk_fields("R2 sel0 masked");
    check("R2 zero-mask write kept sel0", 64'(div_bus_o), 64'(5'h13));

    // R5 PLL decode
    do_req(1'b1, 12'h000, 32'hFFFF_0C35, "R11 write rsp");
    do_req(1'b1, 12'h004, 32'hFFFF_3205, "R11 write rsp");
    do_req(1'b1, 12'h00C, 32'h0300_0100, "R11 write rsp");
    do_req(1'b1, 12'h00C, 32'h0008_0008, "R11 write rsp");
    do_req(1'b0, 12'h00C, 32'h0, "R3 pll word3 readback");
    drain();
    chk_fields("R5 pll");
    check("R5 mode normal", 64'(pll_mode_o), 64'(MODE_NORMAL));
    check("R5 int mode", 64'(pll_int_mode_o), 64'(1));

    // R4 fractional word and lock
    do_req(1'b1, 12'h008, 32'hFFAB_CDEF, "R11 write rsp");
    do_req(1'b0, 12'h008, 32'h0, "R4 frac readback lock low");
    drain();
    @(negedge clk) pll_lock_i = 1'b1;
    repeat (4) @(negedge clk);
    do_req(1'b0, 12'h008, 32'h0, "R4 frac readback lock high");
    do_req(1'b1, 12'h008, 32'h0000_0001, "R11 write rsp");
    do_req(1'b0, 12'h008, 32'h0, "R4 bit31 ignores write");
    drain();
    chk_fields("R4 frac");

    // R7 / R8 gates and soft resets, region boundary 0x10C / 0x110
    do_req(1'b1, 12'h10C, 32'h0005_0005, "R11 write rsp");
    do_req(1'b1, 12'h110, 32'h8001_FFFF, "R11 write rsp");
    do_req(1'b1, 12'h118, 32'hFFFF_00F0, "R11 write rsp");
    do_req(1'b0, 12'h10C, 32'h0, "R7 gate3 readback");
    do_req(1'b0, 12'h110, 32'h0, "R8 rst0 readback");
    drain();
    chk_fields("R7 R8 gate/reset");
    check("R7 clk 48 stopped", 64'(clk_en_o[48]), 64'(0));

    // R9 unmapped offsets
    do_req(1'b1, 12'h11C, 32'hFFFF_FFFF, "R9 write rsp");
    do_req(1'b1, 12'h094, 32'hFFFF_FFFF, "R9 write rsp");
    do_req(1'b1, 12'h010, 32'hFFFF_FFFF, "R9 write rsp");
    do_req(1'b1, 12'hFFC, 32'hFFFF_FFFF, "R9 write rsp");
    do_req(1'b0, 12'h11C, 32'h0, "R9 read unmapped 0x11C");
    do_req(1'b0, 12'h094, 32'h0, "R9 read unmapped 0x094");
    do_req(1'b0, 12'h010, 32'h0, "R9 read unmapped 0x010");
    do_req(1'b0, 12'h0FC, 32'h0, "R9 read unmapped 0x0FC");
    drain();
    chk_fields("R9 unmapped writes");

    // R1 back-pressure sweep
    bp_en = 1'b1;
    rnd = 32'h1357_9BDF;
    for (int i = 0; i < 60; i++) begin
      rnd = {rnd[30:0], rnd[31] ^ rnd[21] ^ rnd[1] ^ rnd[0]};
      if (rnd[4]) do_req(1'b1, map_addr[rnd[3:0]], {rnd[31:16], rnd[27:12]}, "R1 R2 sweep write");
      else        do_req(1'b0, map_addr[rnd[3:0]], 32'h0, "R1 R3 sweep read");
    end
    drain();
    bp_en = 1'b0;
    repeat (3) @(negedge clk);
    chk_fields("R1 after sweep");
    for (int i = 0; i < 16; i++) do_req(1'b0, map_addr[i], 32'h0, "R1 final readback");
    drain();

    done = 1'b1;
    finish_sim();
  end
endmodule